// File: doc/BRIEF.md
# Serial Channel-Command Front End

This block receives framed serial commands for a 32-channel hold controller. A master frames each transfer with an active-low frame signal and a serial clock; both pins, together with the serial data input, are brought into the system clock domain through a flop chain, and all edges are detected there. A 10-bit command word, first bit first, is decoded into a mode, an all-channels (calibrate) flag, an offset-channel flag, a channel number and a test flag. The block then issues a command toward an acquisition controller, arms a readback of one hold register, or both.

A readback is carried by a separate frame that follows the command. At the frame-start edge of that frame, the addressed register word is taken from a register read port and shifted out first bit first. The output-enable pin is high only while the readback frame runs, so the pad can be three-stated at all other times. When a command also asks for an acquisition, the readback waits for the acquisition controller to report completion. The one illegal mode code locks the block until a long clearing frame arrives.

The command port follows valid/ready rules. A command stays presented, with its fields stable, until the cycle in which ready is high. The block has no queue: a word that needs the command port while a command is still presented is dropped whole.

Top module: `hold_cmd_serial`

## Requirements
- R1: After reset, `cmd_valid_o`, `dout_oe_o` and `locked_o` are all low.
- R2: The 10 bits after a frame-start edge (first bit = bit 9) decode as mode in bits 9:8, all-channels in bit 7, offset-select in bit 6, channel in bits 5:1 and test in bit 0. Mode 00 presents one command carrying those fields.
- R3: A presented command holds its fields until it is accepted with `cmd_ready_i` high. A word that needs the command port while one is still presented is discarded.
- R4: When offset-select is 1, the channel is ignored: `cmd_chan_o` and `rd_chan_o` read 0.
- R5: Serial clock falls seen before a frame-start edge, or after the tenth fall of a command frame, are ignored. Extra frame-signal edges inside a frame do not restart it.
- R6: A word with the test bit at 1 produces neither a command nor a readback.
- R7: Mode 01 sets `locked_o`. While it is set, words are not decoded and DOUT stays disabled. It clears only when 24 clock falls follow a single frame-start edge. Each frame-start edge restarts that count, so shorter frames leave the lock in place.
- R8: After a mode 11 word, `rd_chan_o`/`rd_offset_o` show the address. The next frame-start edge samples `rd_data_i` and shifts its 14 bits out, bit 13 first, with `dout_oe_o` high.
- R9: DOUT moves to the next bit only on a serial clock rise, so it is stable across the falling edge on which the master samples it. Bit 13 is valid from the start of the frame.
- R10: Mode 10 presents a command and arms a readback. A frame-start edge before `acq_done_i` pulses, after the command has been accepted, is ignored with DOUT disabled. The first frame after the pulse carries the readback.
- R11: DIN is ignored during a readback frame. After the 14th fall, `dout_oe_o` drops and no command results from that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sync_n_i | input | 1 | Active-low frame pin (asynchronous) |
| din_i | input | 1 | Serial data in, sampled on clock falls |
| dout_o | output | 1 | Serial readback data |
| dout_oe_o | output | 1 | High while readback drives DOUT |
| cmd_valid_o | output | 1 | Command presented |
| cmd_ready_i | input | 1 | Acquisition controller accepts command |
| cmd_all_o | output | 1 | Command targets all channels |
| cmd_offset_o | output | 1 | Command targets the offset channel |
| cmd_chan_o | output | CHAN_W | Channel number |
| acq_done_i | input | 1 | One-cycle pulse: acquisition finished |
| rd_chan_o | output | CHAN_W | Readback channel number |
| rd_offset_o | output | 1 | Readback targets offset channel |
| rd_data_i | input | RB_W | Hold register word for readback |
| locked_o | output | 1 | Illegal-mode lock active |

## Verification
The bench uses the defaults: a 5-bit channel field, 14-bit readback words, a 24-fall clearing frame and two synchroniser stages. It holds each serial clock phase for eight system clocks, so every edge has crossed the synchroniser before the next one. With these values, real-length frames can be run in full. This covers clock falls beyond the tenth, frame-signal glitches inside a frame, a presented command stalled while a second word arrives, a readback frame held off until acquisition completes, and short clearing frames that must not release the lock.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_READ,
    ST_LOCK
  } frame_st_e;

  localparam logic [1:0] MODE_ACQ    = 2'b00;
  localparam logic [1:0] MODE_ILLEGAL = 2'b01;
  localparam logic [1:0] MODE_ACQ_RB = 2'b10;
  localparam logic [1:0] MODE_RB     = 2'b11;
endpackage

// File: rtl/hcs_sync.sv
module hcs_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {STAGES{RST_VAL[g]}};
        prev_q <= RST_VAL[g];
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], pin_i[g]};
        prev_q <= pipe_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign rise_o[g] = pipe_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~pipe_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/hcs_frame.sv
module hcs_frame
  import hcs_pkg::*;
#(
  parameter int CMD_W   = 10,
  parameter int RB_W    = 14,
  parameter int CLR_LEN = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             sync_fall,
  input  logic             din,
  input  logic             rb_go,
  input  logic             rb_hold,
  input  logic [RB_W-1:0]  rd_data,
  output logic             word_done,
  output logic [CMD_W-1:0] word,
  output logic             rb_done,
  output logic             locked,
  output logic             dout,
  output logic             dout_oe
);
  localparam int MAX_A = (CLR_LEN > RB_W) ? CLR_LEN : RB_W;
  localparam int MAX_N = (MAX_A > CMD_W) ? MAX_A : CMD_W;
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] RB_LAST  = CNT_W'(RB_W - 1);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(CLR_LEN - 1);

  frame_st_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] shin_q;
  logic [RB_W-1:0]  shout_q;
  logic             arm_q;
  logic [CMD_W-1:0] word_q;
  logic             word_done_q;
  logic             rb_done_q;
  logic [CMD_W-1:0] word_nxt;

  assign word_nxt = {shin_q[CMD_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      shin_q      <= '0;
      shout_q     <= '0;
      arm_q       <= 1'b0;
      word_q      <= '0;
      word_done_q <= 1'b0;
      rb_done_q   <= 1'b0;
    end else begin
      word_done_q <= 1'b0;
      rb_done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sync_fall) begin
            cnt_q <= '0;
            if (rb_go) begin
              shout_q <= rd_data;
              state_q <= ST_READ;
            end else if (!rb_hold) begin
              state_q <= ST_CMD;
            end
          end
        end
        ST_CMD: begin
          if (sclk_fall) begin
            shin_q <= word_nxt;
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CMD_LAST) begin
              word_q      <= word_nxt;
              word_done_q <= 1'b1;
              arm_q       <= 1'b0;
              if (word_nxt[CMD_W-1 -: 2] == MODE_ILLEGAL) state_q <= ST_LOCK;
              else state_q <= ST_IDLE;
            end
          end
        end
        ST_READ: begin
          if (sclk_fall) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == RB_LAST) begin
              rb_done_q <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end else if (sclk_rise && cnt_q != '0) begin
            shout_q <= {shout_q[RB_W-2:0], 1'b0};
          end
        end
        ST_LOCK: begin
          if (sync_fall) begin
            arm_q <= 1'b1;
            cnt_q <= '0;
          end else if (sclk_fall && arm_q) begin
            if (cnt_q == CLR_LAST) begin
              arm_q   <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_done = word_done_q;
  assign word      = word_q;
  assign rb_done   = rb_done_q;
  assign locked    = (state_q == ST_LOCK);
  assign dout_oe   = (state_q == ST_READ);
  assign dout      = shout_q[RB_W-1];
endmodule

// File: rtl/hcs_decode.sv
module hcs_decode
  import hcs_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int CMD_W  = CHAN_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [CMD_W-1:0]  word,
  input  logic              rb_done,
  input  logic              cmd_ready,
  input  logic              acq_done,
  output logic              cmd_valid,
  output logic              cmd_all,
  output logic              cmd_offset,
  output logic [CHAN_W-1:0] cmd_chan,
  output logic [CHAN_W-1:0] rd_chan,
  output logic              rd_offset,
  output logic              rb_pend,
  output logic              rb_ready
);
  logic [1:0]        f_mode;
  logic              f_all;
  logic              f_off;
  logic [CHAN_W-1:0] f_chan;
  logic              f_test;
  logic [CHAN_W-1:0] chan_eff;
  logic              legal;
  logic              wants_acq;
  logic              wants_rb;
  logic              take;
  logic              armed_q;

  always_comb begin
    f_mode    = word[CMD_W-1 -: 2];
    f_all     = word[CMD_W-3];
    f_off     = word[CMD_W-4];
    f_chan    = word[CHAN_W:1];
    f_test    = word[0];
    chan_eff  = f_off ? '0 : f_chan;
    legal     = (f_mode != MODE_ILLEGAL) && !f_test;
    wants_acq = (f_mode == MODE_ACQ) || (f_mode == MODE_ACQ_RB);
    wants_rb  = f_mode[1];
    take      = word_done && legal && !(wants_acq && cmd_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid  <= 1'b0;
      cmd_all    <= 1'b0;
      cmd_offset <= 1'b0;
      cmd_chan   <= '0;
      rd_chan    <= '0;
      rd_offset  <= 1'b0;
      rb_pend    <= 1'b0;
      rb_ready   <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
        if (rb_pend && !rb_ready) armed_q <= 1'b1;
      end
      if (armed_q && acq_done) begin
        rb_ready <= 1'b1;
        armed_q  <= 1'b0;
      end
      if (rb_done) begin
        rb_pend  <= 1'b0;
        rb_ready <= 1'b0;
        armed_q  <= 1'b0;
      end
      if (take) begin
        if (wants_acq) begin
          cmd_valid  <= 1'b1;
          cmd_all    <= f_all;
          cmd_offset <= f_off;
          cmd_chan   <= chan_eff;
        end
        if (wants_rb) begin
          rb_pend   <= 1'b1;
          rb_ready  <= (f_mode == MODE_RB);
          armed_q   <= 1'b0;
          rd_chan   <= chan_eff;
          rd_offset <= f_off;
        end
      end
    end
  end
endmodule

// File: rtl/hold_cmd_serial.sv
module hold_cmd_serial #(
  parameter int CHAN_W      = 5,
  parameter int RB_W        = 14,
  parameter int CLR_LEN     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_all_o,
  output logic              cmd_offset_o,
  output logic [CHAN_W-1:0] cmd_chan_o,
  input  logic              acq_done_i,
  output logic [CHAN_W-1:0] rd_chan_o,
  output logic              rd_offset_o,
  input  logic [RB_W-1:0]   rd_data_i,
  output logic              locked_o
);
  localparam int CMD_W = CHAN_W + 5;

  logic [2:0]       pin_lvl;
  logic [2:0]       pin_rise;
  logic [2:0]       pin_fall;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             sync_fall;
  logic             din_s;
  logic             word_done;
  logic [CMD_W-1:0] word;
  logic             rb_done;
  logic             rb_pend;
  logic             rb_ready;
  logic [5:0]       sync_unused;

  // bit 0 serial clock (idle low), bit 1 frame (idle high), bit 2 data
  hcs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({din_i, sync_n_i, sclk_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign sclk_rise   = pin_rise[0];
  assign sclk_fall   = pin_fall[0];
  assign sync_fall   = pin_fall[1];
  assign din_s       = pin_lvl[2];
  assign sync_unused = {pin_lvl[1:0], pin_rise[2:1], pin_fall[2], 1'b0};

  hcs_frame #(.CMD_W(CMD_W), .RB_W(RB_W), .CLR_LEN(CLR_LEN)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sync_fall (sync_fall),
    .din       (din_s),
    .rb_go     (rb_pend & rb_ready),
    .rb_hold   (rb_pend & ~rb_ready),
    .rd_data   (rd_data_i),
    .word_done (word_done),
    .word      (word),
    .rb_done   (rb_done),
    .locked    (locked_o),
    .dout      (dout_o),
    .dout_oe   (dout_oe_o)
  );

  hcs_decode #(.CHAN_W(CHAN_W), .CMD_W(CMD_W)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_done  (word_done),
    .word       (word),
    .rb_done    (rb_done),
    .cmd_ready  (cmd_ready_i),
    .acq_done   (acq_done_i),
    .cmd_valid  (cmd_valid_o),
    .cmd_all    (cmd_all_o),
    .cmd_offset (cmd_offset_o),
    .cmd_chan   (cmd_chan_o),
    .rd_chan    (rd_chan_o),
    .rd_offset  (rd_offset_o),
    .rb_pend    (rb_pend),
    .rb_ready   (rb_ready)
  );
endmodule

// File: rtl/hcs_chk.sv
module hcs_chk #(
  parameter int CHAN_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_all,
  input logic              cmd_offset,
  input logic [CHAN_W-1:0] cmd_chan,
  input logic              dout,
  input logic              dout_oe,
  input logic              locked,
  input logic              sclk_rise,
  input logic              rb_ready
);
  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_chan) && $stable(cmd_all) && $stable(cmd_offset));

  // R4
  offset_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_offset |-> cmd_chan == '0);

  // R7
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !dout_oe);

  // R7
  lock_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> !locked);

  // R9
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe && $past(dout_oe) && !$past(sclk_rise) |-> $stable(dout));

  // R10
  rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(rb_ready));
endmodule

bind hold_cmd_serial hcs_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid_o),
  .cmd_ready  (cmd_ready_i),
  .cmd_all    (cmd_all_o),
  .cmd_offset (cmd_offset_o),
  .cmd_chan   (cmd_chan_o),
  .dout       (dout_o),
  .dout_oe    (dout_oe_o),
  .locked     (locked_o),
  .sclk_rise  (sclk_rise),
  .rb_ready   (rb_ready)
);

// File: tb/hold_cmd_serial_tb.sv
module hold_cmd_serial_tb;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sync_n = 1'b1;
  logic        din = 1'b0;
  logic        dout, dout_oe, cmd_valid, cmd_all, cmd_offset, rd_offset, locked;
  logic        cmd_ready = 1'b1;
  logic        acq_done = 1'b0;
  logic [4:0]  cmd_chan, rd_chan;
  logic [13:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [6:0] exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [13:0] rb_model(input logic [4:0] ch, input logic off);
    return off ? 14'h3A5C : {ch, ch ^ 5'h15, 4'h9};
  endfunction

  assign rd_data = rb_model(rd_chan, rd_offset);

  hold_cmd_serial u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_all_o(cmd_all), .cmd_offset_o(cmd_offset), .cmd_chan_o(cmd_chan),
    .acq_done_i(acq_done), .rd_chan_o(rd_chan), .rd_offset_o(rd_offset),
    .rd_data_i(rd_data), .locked_o(locked)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input int k);
    repeat (k) @(negedge clk);
  endtask

  // scoreboard monitor: every accepted command must match the queue head
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) chk(0, "R2", "unexpected command", int'({cmd_all, cmd_offset, cmd_chan}), 0);
      else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        chk({cmd_all, cmd_offset, cmd_chan} == e, "R2", "command fields",
            int'({cmd_all, cmd_offset, cmd_chan}), int'(e));
      end
    end
  end

  task automatic frame(input logic [23:0] bits, input int n, input int glitch);
    @(negedge clk) sync_n = 1'b0;
    hw(HALF);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; din = bits[23-i];
      hw(HALF);
      if (i == glitch) begin
        sync_n = 1'b1; hw(HALF);
        sync_n = 1'b0; hw(HALF);
      end
      sclk = 1'b0;
      hw(HALF);
    end
    sync_n = 1'b1;
    hw(2 * HALF);
  endtask

  task automatic send_cmd(input logic [1:0] mode, input logic cal, input logic off,
                          input logic [4:0] ch, input logic tst, input bit push);
    if (push) exp_q.push_back({cal, off, off ? 5'd0 : ch});
    frame({mode, cal, off, ch, tst, 14'd0}, 10, -1);
  endtask

  task automatic read_frame(input logic [13:0] exp, input bit active,
                            input logic [23:0] dpat, input string req);
    @(negedge clk) sync_n = 1'b0;
    hw(HALF);
    for (int i = 0; i < 14; i++) begin
      sclk = 1'b1; din = dpat[23-i];
      hw(HALF - 1);
      if (active) chk(dout_oe === 1'b1 && dout === exp[13-i], req, "readback bit", int'({dout_oe, dout}), int'({1'b1, exp[13-i]}));
      else chk(dout_oe === 1'b0, req, "dout enabled", int'(dout_oe), 0);
      hw(1);
      sclk = 1'b0;
      hw(HALF - 1);
      if (active && i < 13) chk(dout === exp[13-i], "R9", "bit moved at fall", int'(dout), int'(exp[13-i]));
      hw(1);
    end
    sync_n = 1'b1;
    hw(2 * HALF);
    chk(dout_oe === 1'b0, "R11", "dout_oe after frame", int'(dout_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    hw(10);
    rst_n = 1'b1;
    hw(4);
    // R1
    chk(cmd_valid === 0 && dout_oe === 0 && locked === 0, "R1", "reset state",
        int'({cmd_valid, dout_oe, locked}), 0);

    // R5: clock activity before any frame start
    din = 1'b1;
    for (int i = 0; i < 5; i++) begin sclk = 1'b1; hw(HALF); sclk = 1'b0; hw(HALF); end
    send_cmd(2'b00, 0, 0, 5'd19, 0, 1);
    // R2: all-channels flag
    send_cmd(2'b00, 1, 0, 5'd7, 0, 1);
    // R4: offset select zeroes the channel
    send_cmd(2'b00, 0, 1, 5'd22, 0, 1);
    // R5: three surplus clocks, then a frame-signal glitch mid-frame
    exp_q.push_back({1'b0, 1'b0, 5'd10});
    frame({2'b00, 1'b0, 1'b0, 5'd10, 1'b0, 14'h3FFF}, 13, -1);
    exp_q.push_back({1'b0, 1'b0, 5'd29});
    frame({2'b00, 1'b0, 1'b0, 5'd29, 1'b0, 14'h0}, 10, 4);
    chk(exp_q.size() == 0, "R5", "commands outstanding", exp_q.size(), 0);

    // R3: stall, then a second word is dropped
    cmd_ready = 1'b0;
    send_cmd(2'b00, 0, 0, 5'd3, 0, 1);
    chk(cmd_valid === 1 && cmd_chan === 5'd3, "R3", "presented command", int'({cmd_valid, cmd_chan}), int'({1'b1, 5'd3}));
    send_cmd(2'b00, 0, 0, 5'd9, 0, 0);
    chk(cmd_chan === 5'd3, "R3", "held channel", int'(cmd_chan), 3);
    @(negedge clk) cmd_ready = 1'b1;
    hw(4);
    chk(cmd_valid === 0 && exp_q.size() == 0, "R3", "drained", int'(cmd_valid), 0);

    // R6: test bit set discards both kinds of word
    send_cmd(2'b00, 0, 0, 5'd5, 1, 0);
    send_cmd(2'b11, 0, 0, 5'd5, 1, 0);
    read_frame(14'd0, 0, 24'hFFFFFF, "R6");

    // R8 and R11: readback only, DIN toggling during the frame
    send_cmd(2'b11, 0, 0, 5'd12, 0, 0);
    chk(rd_chan === 5'd12 && rd_offset === 0, "R8", "read address", int'({rd_offset, rd_chan}), 12);
    read_frame(rb_model(5'd12, 0), 1, 24'h555555, "R8");
    chk(locked === 0 && cmd_valid === 0, "R11", "din decoded in readback", int'({locked, cmd_valid}), 0);
    send_cmd(2'b11, 0, 1, 5'd30, 0, 0);
    chk(rd_chan === 5'd0 && rd_offset === 1, "R4", "offset read address", int'({rd_offset, rd_chan}), 32);
    read_frame(rb_model(5'd0, 1), 1, 24'hAAAAAA, "R8");

    // R10: acquire-then-readback waits for completion
    send_cmd(2'b10, 0, 0, 5'd27, 0, 1);
    read_frame(14'd0, 0, 24'hFFFFFF, "R10");
    @(negedge clk) acq_done = 1'b1;
    @(negedge clk) acq_done = 1'b0;
    hw(2);
    read_frame(rb_model(5'd27, 0), 1, 24'h555555, "R10");

    // R7: illegal mode lock and its clearing rule
    send_cmd(2'b01, 0, 0, 5'd0, 0, 0);
    chk(locked === 1, "R7", "lock set", int'(locked), 1);
    send_cmd(2'b00, 0, 0, 5'd1, 0, 0);
    frame(24'hFFFFFF, 12, -1);
    frame(24'hFFFFFF, 12, -1);
    chk(locked === 1, "R7", "short frames cleared lock", int'(locked), 1);
    frame(24'h0, 24, -1);
    chk(locked === 0, "R7", "long frame clear", int'(locked), 0);
    send_cmd(2'b00, 0, 0, 5'd14, 0, 1);
    hw(4);
    chk(exp_q.size() == 0, "R2", "commands outstanding", exp_q.size(), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule